// File: doc/BRIEF.md
# Page-Mode Burst Address Generator

This block produces the word addresses for a burst read from a page-mode ROM. The bus master hands over only the address of the first word together with a start pulse. The block registers that address, presents it on its output, and then forms every following word address itself. Each advance strobe from the access timer moves the address to the next word.

The counting direction comes from the low nibble of the start address. A nibble of 0x0 counts upward in steps of four bytes. A nibble of 0xC counts downward in steps of four bytes. Any other nibble counts upward and raises an alignment flag. When the request is not a page-mode burst, the address passes through and is held, and no counting takes place. A done pulse marks the end of the programmed number of words. Only then can a new burst be accepted.

Top module: `page_burst_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and `busy_o`, `done_o` and `bad_align_o` are all 0.
- R2: A start pulse accepted with `page_mode_i`=1 loads `start_addr_i` onto `addr_o` on the next clock edge and sets `busy_o`.
- R3: When bits [3:0] of the start address are 0x0, each advance strobe during a burst adds 4 to `addr_o` (for example 0x..0, 0x..4, 0x..8, 0x..C).
- R4: When bits [3:0] of the start address are 0xC, each advance strobe during a burst subtracts 4 from `addr_o` (for example 0x..C, 0x..8, 0x..4, 0x..0).
- R5: `addr_o` changes only on the clock edge that samples an advance strobe or an accepted start. Between strobes it holds its value.
- R6: `burst_len_i` = L (0 to 3) selects L+1 words. The (L+1)th advance strobe does not move the address. Instead `done_o` pulses high for exactly one cycle and `busy_o` falls on the same edge.
- R7: A start address whose bits [3:0] are neither 0x0 nor 0xC counts upward by 4. `bad_align_o` is 1 from the cycle after that start until the next accepted start.
- R8: While `busy_o` is 1, a start pulse is ignored: the address, the direction and the word count of the running burst are unchanged.
- R9: A start with `page_mode_i`=0 is a single access. `addr_o` takes `start_addr_i` and `busy_o` stays 0. Later advance strobes leave `addr_o` unchanged and raise no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse carrying the first word address |
| start_addr_i | input | ADDR_W | Address of the first word, supplied by the master |
| page_mode_i | input | 1 | 1 when the request is a burst to a page-mode channel |
| burst_len_i | input | LEN_W | Number of words minus one |
| advance_i | input | 1 | Per-word strobe from the access timer |
| addr_o | output | ADDR_W | Registered current word address |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse when the last word has been issued |
| bad_align_o | output | 1 | Start nibble was neither 0x0 nor 0xC |

## Verification
A wrong direction bit shows up at `addr_o` on the first advance after the start: the value lands 8 away from the expected one. A wrong word count shows up as `done_o` arriving one strobe early or late, or as the address moving on the strobe that should end the burst. A lost busy state shows up as an accepted start that should have been ignored, or as a single access that reacts to strobes. All of these are visible one clock after the strobe or start that triggers them.

// File: rtl/pba_pkg.sv
package pba_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } pba_dir_e;

    localparam logic [3:0] NIB_ASCEND  = 4'h0;
    localparam logic [3:0] NIB_DESCEND = 4'hC;
endpackage

// File: rtl/pba_dir_decode.sv
module pba_dir_decode
    import pba_pkg::*;
(
    input  logic [3:0] nibble_i,
    output pba_dir_e   dir_o,
    output logic       bad_o
);
    always_comb begin
        dir_o = DIR_UP;
        bad_o = 1'b0;
        if (nibble_i == NIB_DESCEND) begin
            dir_o = DIR_DOWN;
        end else if (nibble_i != NIB_ASCEND) begin
            bad_o = 1'b1;
        end
    end
endmodule

// File: rtl/pba_step.sv
module pba_step
    import pba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  pba_dir_e          dir_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb begin
        if (dir_i == DIR_DOWN) addr_o = addr_i - STEP_V;
        else                   addr_o = addr_i + STEP_V;
    end
endmodule

// File: rtl/page_burst_addr_gen.sv
module page_burst_addr_gen
    import pba_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 2,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              page_mode_i,
    input  logic [LEN_W-1:0]  burst_len_i,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              bad_align_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  left;
        pba_dir_e          dir;
        logic              busy;
        logic              done;
        logic              bad;
    } state_t;

    state_t            st_d, st_q;
    pba_dir_e          dec_dir;
    logic              dec_bad;
    logic [ADDR_W-1:0] next_addr;
    logic              accept;

    pba_dir_decode u_dec (
        .nibble_i (start_addr_i[3:0]),
        .dir_o    (dec_dir),
        .bad_o    (dec_bad)
    );

    pba_step #(.ADDR_W(ADDR_W), .STEP(STEP)) u_step (
        .addr_i (st_q.addr),
        .dir_i  (st_q.dir),
        .addr_o (next_addr)
    );

    assign accept = start_i && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (accept) begin
            st_d.addr = start_addr_i;
            st_d.bad  = page_mode_i && dec_bad;
            st_d.busy = page_mode_i;
            st_d.left = burst_len_i;
            st_d.dir  = page_mode_i ? dec_dir : DIR_UP;
        end else if (st_q.busy && advance_i) begin
            if (st_q.left == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.addr = next_addr;
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{addr: '0, left: '0, dir: DIR_UP, busy: 1'b0, done: 1'b0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o      = st_q.addr;
    assign busy_o      = st_q.busy;
    assign done_o      = st_q.done;
    assign bad_align_o = st_q.bad;
endmodule

// File: rtl/page_burst_addr_gen_chk.sv
module page_burst_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] start_addr_i,
    input logic              page_mode_i,
    input logic              advance_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              bad_align_o
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (addr_o == $past(start_addr_i) && busy_o == $past(page_mode_i))); // R2

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && advance_i) |=> (done_o || addr_o == $past(addr_o) + STEP_V || addr_o == $past(addr_o) - STEP_V)); // R3

    AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance_i && !(start_i && !busy_o)) |=> $stable(addr_o)); // R5

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o) && $past(advance_i))); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6

    AST_BAD_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && page_mode_i && start_addr_i[3:0] != 4'h0 && start_addr_i[3:0] != 4'hC) |=> bad_align_o); // R7

    AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !advance_i) |=> (busy_o && $stable(addr_o))); // R8

    AST_SINGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !done_o)); // R9
endmodule

bind page_burst_addr_gen page_burst_addr_gen_chk #(.ADDR_W(ADDR_W), .STEP(STEP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .page_mode_i  (page_mode_i),
    .advance_i    (advance_i),
    .addr_o       (addr_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .bad_align_o  (bad_align_o)
);

// File: tb/page_burst_addr_gen_bench.sv
module page_burst_addr_gen_bench;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 2;
    localparam int NVEC   = 6;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  len;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{addr: 32'h0000_1000, len: 2'd3},
        '{addr: 32'h0000_200C, len: 2'd3},
        '{addr: 32'h0000_3000, len: 2'd0},
        '{addr: 32'h0000_4004, len: 2'd2},
        '{addr: 32'h0000_000C, len: 2'd3},
        '{addr: 32'hFFFF_FFF0, len: 2'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] start_addr_i = '0;
    logic              page_mode_i = 1'b0;
    logic [LEN_W-1:0]  burst_len_i = '0;
    logic              advance_i = 1'b0;
    logic [ADDR_W-1:0] addr_o;
    logic              busy_o, done_o, bad_align_o;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    page_burst_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_page_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
        .page_mode_i(page_mode_i), .burst_len_i(burst_len_i), .advance_i(advance_i),
        .addr_o(addr_o), .busy_o(busy_o), .done_o(done_o), .bad_align_o(bad_align_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [31:0] a, input logic [1:0] l, input logic pm);
        @(negedge clk);
        start_i = 1'b1; start_addr_i = a; burst_len_i = l; page_mode_i = pm;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic do_adv();
        @(negedge clk);
        advance_i = 1'b1;
        @(negedge clk);
        advance_i = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_a;
        logic        down;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 addr", addr_o, 0);
        check("R1 busy", {31'b0, busy_o}, 0);
        check("R1 done", {31'b0, done_o}, 0);
        check("R1 bad", {31'b0, bad_align_o}, 0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            exp_a = VECS[v].addr;
            down  = (VECS[v].addr[3:0] == 4'hC);
            do_start(VECS[v].addr, VECS[v].len, 1'b1);
            check("R2 first addr", addr_o, exp_a);
            check("R2 busy", {31'b0, busy_o}, 1);
            check("R7 bad flag", {31'b0, bad_align_o},
                  {31'b0, (VECS[v].addr[3:0] != 4'h0 && VECS[v].addr[3:0] != 4'hC)});
            for (int w = 0; w < int'(VECS[v].len); w++) begin
                do_adv();
                exp_a = down ? exp_a - 32'd4 : exp_a + 32'd4;
                check(down ? "R4 down step" : "R3 up step", addr_o, exp_a);
                check("R6 no early done", {31'b0, done_o}, 0);
            end
            do_adv();
            check("R6 done pulse", {31'b0, done_o}, 1);
            check("R6 busy clear", {31'b0, busy_o}, 0);
            check("R6 addr kept on last strobe", addr_o, exp_a);
            @(negedge clk);
            check("R6 done one cycle", {31'b0, done_o}, 0);
        end

        // R5 hold between strobes, with gaps
        do_start(32'h0000_5000, 2'd3, 1'b1);
        repeat (4) @(negedge clk);
        check("R5 hold", addr_o, 32'h0000_5000);
        do_adv();
        repeat (3) @(negedge clk);
        check("R5 hold after step", addr_o, 32'h0000_5004);

        // R8 start while busy is ignored
        do_start(32'h0000_900C, 2'd0, 1'b1);
        check("R8 addr unchanged", addr_o, 32'h0000_5004);
        check("R8 still busy", {31'b0, busy_o}, 1);
        do_adv();
        check("R8 direction kept", addr_o, 32'h0000_5008);
        do_adv();
        check("R8 count kept", addr_o, 32'h0000_500C);
        check("R8 no done yet", {31'b0, done_o}, 0);
        do_adv();
        check("R8 done after four words", {31'b0, done_o}, 1);

        // R9 single access pass-through
        do_start(32'h0000_ABC4, 2'd3, 1'b0);
        check("R9 addr passed", addr_o, 32'h0000_ABC4);
        check("R9 not busy", {31'b0, busy_o}, 0);
        check("R9 bad cleared", {31'b0, bad_align_o}, 0);
        do_adv();
        check("R9 advance ignored", addr_o, 32'h0000_ABC4);
        check("R9 no done", {31'b0, done_o}, 0);

        // R7 flag persists until next accepted start
        do_start(32'h0000_0008, 2'd1, 1'b1);
        do_adv();
        check("R7 odd nibble counts up", addr_o, 32'h0000_000C);
        do_adv();
        @(negedge clk);
        check("R7 flag held", {31'b0, bad_align_o}, 1);
        do_start(32'h0000_0010, 2'd0, 1'b1);
        check("R7 flag cleared", {31'b0, bad_align_o}, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule